// File: doc/BRIEF.md
# Frame Control Latch and Sequencer

This block sits in front of the signal-processing core of a speech echo canceller. It samples six mode pins and holds their decoded values for the length of one 8 kHz processing frame. The pins select through mode, coefficient hold, attenuation, gain control, center clip and howling detect. A frame begins on a high-to-low edge of the frame interrupt. The mode pins are sampled at that edge, and also once on the first cycle after reset is released. The decoded enables stay fixed until the next such event, so the core never sees a mode change in the middle of a frame.

The block also sequences the life of the core. Reset is applied asynchronously and released through a two-stage synchronizer. After release, a lockout of `LOCK_CYCLES` core clocks ignores frame interrupts while the core initializes. Each accepted frame gives a one-cycle start strobe. In through mode, that strobe comes with a coefficient-clear request. A busy window of `FRAME_CYCLES` clocks follows, and at its end a done level is set. In power down, the serial and clock output enables are dropped, interrupts are ignored, and the done level and latched modes are frozen. In through mode, a byte selector routes the raw receive and send bytes to the outputs in place of the processed ones.

Top module: `frame_ctl_seq`

## Requirements
- R1: On the first clock after the synchronized reset release, the mode pins are captured and decoded. thru_en = pin_thru, hold_en = pin_hold, att_en = NOT pin_att_n, gc_en = pin_gc, clip_en = pin_clip, howl_en = NOT pin_howl_n.
- R2: A high-to-low transition of frame_irq that is accepted captures the mode pins with the R1 decoding. It also raises frame_start for exactly one cycle, in the same cycle the new enables appear.
- R3: Mode pin changes that do not coincide with an accepted interrupt edge or a reset release leave the six enables unchanged.
- R4: For LOCK_CYCLES clocks after the synchronized reset release, interrupt edges are ignored: no frame_start is produced and the enables keep their reset-release values.
- R5: When thru_en is latched, rx_sel equals rx_raw and tx_sel equals tx_raw. Otherwise rx_sel equals rx_proc and tx_sel equals tx_proc.
- R6: coef_clear is asserted only together with frame_start, and it is asserted exactly when the frame's latched thru_en is 1.
- R7: coef_upd_en is high only while a frame is being processed, and only with both hold_en and thru_en at 0.
- R8: frame_done falls with frame_start and rises exactly FRAME_CYCLES clocks after the frame_start cycle, then stays high until the next frame_start.
- R9: While pwr_n is low, ser_oe and clk_oe are 0 and frame_done keeps its value.
- R10: While reset is applied, ser_oe, frame_done, frame_start and all enables are 0. clk_oe depends only on pwr_n.
- R11: An interrupt edge that reaches the block in the same cycle as power-down entry is ignored. It produces no frame_start and no change of the enables, and is not replayed after power returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_n | input | 1 | Power-down request, active low |
| frame_irq | input | 1 | Frame interrupt; falling edge starts a frame |
| pin_thru | input | 1 | Through mode pin, active high |
| pin_hold | input | 1 | Coefficient hold pin, active high |
| pin_att_n | input | 1 | Attenuator pin, low enables |
| pin_gc | input | 1 | Gain control pin, high enables |
| pin_clip | input | 1 | Center clip pin, high enables |
| pin_howl_n | input | 1 | Howling detect pin, low enables |
| rx_raw | input | BYTE_W | Unprocessed receive byte |
| tx_raw | input | BYTE_W | Unprocessed send byte |
| rx_proc | input | BYTE_W | Processed receive byte from the core |
| tx_proc | input | BYTE_W | Processed send byte from the core |
| thru_en | output | 1 | Latched through mode |
| hold_en | output | 1 | Latched coefficient hold |
| att_en | output | 1 | Latched attenuator enable |
| gc_en | output | 1 | Latched gain control enable |
| clip_en | output | 1 | Latched center clip enable |
| howl_en | output | 1 | Latched howling detect enable |
| frame_start | output | 1 | One-cycle frame start strobe |
| coef_clear | output | 1 | Coefficient clear request |
| coef_upd_en | output | 1 | Coefficient update permission |
| frame_done | output | 1 | Frame processing complete level |
| ser_oe | output | 1 | Serial output drive enable |
| clk_oe | output | 1 | Clock output drive enable |
| rx_sel | output | BYTE_W | Receive byte to the output stage |
| tx_sel | output | BYTE_W | Send byte to the output stage |

## Verification
Two functions can fall in the same cycle: interrupt-edge acceptance and power-down entry. The bench provokes this by lowering pwr_n and frame_irq at the same clock edge. Both inputs pass through synchronizers of equal depth, so they reach the decision logic together. The bench judges the outcome at the ports. The scoreboard must see no frame_start, the enables and frame_done must keep their prior values, and no frame may appear once power returns. A second collision is an interrupt edge inside the post-reset lockout, which must also produce no strobe.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int NUM_PINS = 6;

  typedef struct packed {
    logic thru;
    logic hold;
    logic att;
    logic gc;
    logic clip;
    logic howl;
  } mode_t;

  // raw pin order: {thru, hold, att_n, gc, clip, howl_n}
  function automatic mode_t decode_pins(input logic [NUM_PINS-1:0] raw);
    mode_t m;
    m.thru = raw[5];
    m.hold = raw[4];
    m.att  = ~raw[3];
    m.gc   = raw[2];
    m.clip = raw[1];
    m.howl = ~raw[0];
    return m;
  endfunction

  function automatic logic upd_allowed(input logic busy, input mode_t m);
    return busy & ~m.hold & ~m.thru;
  endfunction
endpackage

// File: rtl/fcs_sync.sv
module fcs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    stg[0] <= d;
    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fcs_rst_sync.sv
module fcs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic meta_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_s_n = hold_q;

  // R10: release can only follow a cycle where the first stage was already high
  p_release_staged_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_s_n) |-> $past(meta_q));
endmodule

// File: rtl/fcs_lockout.sv
module fcs_lockout #(
  parameter int LOCK_CYCLES = 1920000
) (
  input  logic clk,
  input  logic rst_s_n,
  input  logic run,
  output logic lock_done
);
  localparam int LW = $clog2(LOCK_CYCLES + 2);

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)                      cnt_q <= LW'(LOCK_CYCLES);
    else if (run && cnt_q != '0)       cnt_q <= cnt_q - LW'(1);
  end

  assign lock_done = (cnt_q == '0);

  // R4: once the lockout has expired it never returns until the next reset
  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    lock_done |=> lock_done);
endmodule

// File: rtl/fcs_frame_seq.sv
module fcs_frame_seq #(
  parameter int FRAME_CYCLES = 2400
) (
  input  logic clk,
  input  logic rst_s_n,
  input  logic run,
  input  logic go,
  output logic busy,
  output logic done
);
  localparam int FW = $clog2(FRAME_CYCLES + 1);

  logic [FW-1:0] cnt_q;
  logic          done_q;
  logic          last_tick;

  assign last_tick = run && (cnt_q == FW'(1));

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (go) begin
      cnt_q  <= FW'(FRAME_CYCLES);
      done_q <= 1'b0;
    end else if (run && cnt_q != '0) begin
      cnt_q  <= cnt_q - FW'(1);
      if (last_tick) done_q <= 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
  assign done = done_q;

  // R8: a new frame always clears the done level in the next cycle
  p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    go |=> !done);
  // R8: done and busy never overlap
  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy |-> !done);
  // R9: power down freezes the done level
  p_done_frozen_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !run |=> $stable(done));
endmodule

// File: rtl/frame_ctl_seq.sv
module frame_ctl_seq
  import fcs_pkg::*;
#(
  parameter int LOCK_CYCLES  = 1920000,
  parameter int FRAME_CYCLES = 2400,
  parameter int BYTE_W       = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_n,
  input  logic              frame_irq,
  input  logic              pin_thru,
  input  logic              pin_hold,
  input  logic              pin_att_n,
  input  logic              pin_gc,
  input  logic              pin_clip,
  input  logic              pin_howl_n,
  input  logic [BYTE_W-1:0] rx_raw,
  input  logic [BYTE_W-1:0] tx_raw,
  input  logic [BYTE_W-1:0] rx_proc,
  input  logic [BYTE_W-1:0] tx_proc,
  output logic              thru_en,
  output logic              hold_en,
  output logic              att_en,
  output logic              gc_en,
  output logic              clip_en,
  output logic              howl_en,
  output logic              frame_start,
  output logic              coef_clear,
  output logic              coef_upd_en,
  output logic              frame_done,
  output logic              ser_oe,
  output logic              clk_oe,
  output logic [BYTE_W-1:0] rx_sel,
  output logic [BYTE_W-1:0] tx_sel
);
  localparam int IN_W = NUM_PINS + 2;

  logic            rst_s_n;
  logic [IN_W-1:0] in_raw, in_s;
  logic            irq_s, pwr_s, pd;
  logic [NUM_PINS-1:0] pins_s;
  mode_t           pins_dec;

  logic irq_prev_q, up_q;
  logic irq_fall, acc_fall, rel_first, latch_now;
  logic lock_done, busy, done_w;
  mode_t mode_q;
  logic start_q, clr_q;

  fcs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  // interrupt, power request and mode pins share one synchronizer depth
  assign in_raw = {frame_irq, pwr_n, pin_thru, pin_hold, pin_att_n,
                   pin_gc, pin_clip, pin_howl_n};

  fcs_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk(clk), .d(in_raw), .q(in_s));

  assign irq_s    = in_s[IN_W-1];
  assign pwr_s    = in_s[IN_W-2];
  assign pins_s   = in_s[NUM_PINS-1:0];
  assign pd       = ~pwr_s;
  assign pins_dec = decode_pins(pins_s);

  fcs_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst_s_n(rst_s_n), .run(~pd), .lock_done(lock_done));

  // named events for checking
  assign irq_fall  = irq_prev_q & ~irq_s;
  assign acc_fall  = irq_fall & lock_done & ~pd;
  assign rel_first = ~up_q;
  assign latch_now = acc_fall | rel_first;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      irq_prev_q <= 1'b0;
      up_q       <= 1'b0;
      mode_q     <= '0;
      start_q    <= 1'b0;
      clr_q      <= 1'b0;
    end else begin
      irq_prev_q <= irq_s;
      up_q       <= 1'b1;
      if (latch_now) mode_q <= pins_dec;
      start_q    <= acc_fall;
      clr_q      <= acc_fall & pins_dec.thru;
    end
  end

  fcs_frame_seq #(.FRAME_CYCLES(FRAME_CYCLES)) u_seq (
    .clk(clk), .rst_s_n(rst_s_n), .run(~pd), .go(acc_fall),
    .busy(busy), .done(done_w));

  assign thru_en     = mode_q.thru;
  assign hold_en     = mode_q.hold;
  assign att_en      = mode_q.att;
  assign gc_en       = mode_q.gc;
  assign clip_en     = mode_q.clip;
  assign howl_en     = mode_q.howl;
  assign frame_start = start_q;
  assign coef_clear  = clr_q;
  assign coef_upd_en = upd_allowed(busy, mode_q);
  assign frame_done  = done_w;
  assign ser_oe      = rst_s_n & ~pd;
  assign clk_oe      = ~pd;

  generate
    if (BYTE_W > 0) begin : g_bypass
      assign rx_sel = mode_q.thru ? rx_raw : rx_proc;
      assign tx_sel = mode_q.thru ? tx_raw : tx_proc;
    end
  endgenerate

  // R2: latched modes only move after a latch event
  p_mode_change_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode_q != $past(mode_q)) |-> $past(latch_now));
  // R2: start strobe lasts one cycle
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    frame_start |=> !frame_start || $past(acc_fall));
  // R4: no frame starts while the lockout is running
  p_start_lock_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    frame_start |-> $past(lock_done));
  // R6: clear request only with a start in through mode
  p_clear_thru_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    coef_clear |-> (frame_start && thru_en));
  // R7: updates only inside a frame window
  p_upd_busy_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    coef_upd_en |-> !frame_done);
  // R9 and R11: no start follows a power-down cycle
  p_pd_nostart_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    $past(pd) |-> !frame_start);
endmodule

// File: tb/tb_frame_ctl_seq.sv
`timescale 1ns/1ps
module tb_frame_ctl_seq;
  localparam int LOCK  = 40;
  localparam int FRAME = 12;
  localparam int BW    = 8;

  logic clk = 1'b0;
  logic rst_n, pwr_n, frame_irq;
  logic [5:0] pins;   // {thru, hold, att_n, gc, clip, howl_n}
  logic [BW-1:0] rx_raw, tx_raw, rx_proc, tx_proc;
  logic thru_en, hold_en, att_en, gc_en, clip_en, howl_en;
  logic frame_start, coef_clear, coef_upd_en, frame_done, ser_oe, clk_oe;
  logic [BW-1:0] rx_sel, tx_sel;

  int checks = 0;
  int errors = 0;
  logic [6:0] exp_q [$];   // {mode6, clear}

  always #10 clk = ~clk;

  frame_ctl_seq #(.LOCK_CYCLES(LOCK), .FRAME_CYCLES(FRAME), .BYTE_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .frame_irq(frame_irq),
    .pin_thru(pins[5]), .pin_hold(pins[4]), .pin_att_n(pins[3]),
    .pin_gc(pins[2]), .pin_clip(pins[1]), .pin_howl_n(pins[0]),
    .rx_raw(rx_raw), .tx_raw(tx_raw), .rx_proc(rx_proc), .tx_proc(tx_proc),
    .thru_en(thru_en), .hold_en(hold_en), .att_en(att_en), .gc_en(gc_en),
    .clip_en(clip_en), .howl_en(howl_en), .frame_start(frame_start),
    .coef_clear(coef_clear), .coef_upd_en(coef_upd_en), .frame_done(frame_done),
    .ser_oe(ser_oe), .clk_oe(clk_oe), .rx_sel(rx_sel), .tx_sel(tx_sel));

  // expected enables: polarity per requirement text
  function automatic logic [5:0] want(input logic [5:0] r);
    return {r[5], r[4], ~r[3], r[2], r[1], ~r[0]};
  endfunction

  function automatic logic [5:0] modes();
    return {thru_en, hold_en, att_en, gc_en, clip_en, howl_en};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: every start must match the head of the scoreboard
  always @(negedge clk) begin
    if (frame_start === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4/R11 unexpected frame_start actual=1 expected=0");
      end else begin
        logic [6:0] e;
        e = exp_q.pop_front();
        chk("R2 modes at start", {26'd0, modes()}, {26'd0, e[6:1]});
        chk("R6 coef_clear", {31'd0, coef_clear}, {31'd0, e[0]});
      end
    end
  end

  // driver: run an accepted frame and check done timing
  task automatic run_frame(input logic [5:0] raw);
    logic [5:0] w;
    int k;
    w = want(raw);
    pins = raw;
    ticks(1);
    exp_q.push_back({w, raw[5]});
    frame_irq = 1'b0;
    k = 0;
    while (frame_start !== 1'b1 && k < 10) begin
      @(negedge clk); k++;
    end
    chk("R2 start seen", {31'd0, frame_start}, 32'd1);
    chk("R8 done falls with start", {31'd0, frame_done}, 32'd0);
    for (int j = 1; j <= FRAME; j++) begin
      @(negedge clk);
      if (j == 1) begin
        frame_irq = 1'b1;
        chk("R7 coef_upd_en", {31'd0, coef_upd_en}, {31'd0, ~raw[4] & ~raw[5]});
        chk("R2 start one cycle", {31'd0, frame_start}, 32'd0);
      end
      if (j == FRAME-1) chk("R8 done before window", {31'd0, frame_done}, 32'd0);
      if (j == FRAME)   chk("R8 done at window", {31'd0, frame_done}, 32'd1);
    end
    chk("R7 no update after frame", {31'd0, coef_upd_en}, 32'd0);
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pwr_n = 1'b1; frame_irq = 1'b1;
    pins = 6'b101010;
    rx_raw = 8'hA5; tx_raw = 8'h3C; rx_proc = 8'h11; tx_proc = 8'hE2;
    ticks(6);
    chk("R10 ser_oe in reset", {31'd0, ser_oe}, 32'd0);
    chk("R10 done in reset", {31'd0, frame_done}, 32'd0);
    chk("R10 enables in reset", {26'd0, modes()}, 32'd0);
    chk("R10 clk_oe in reset", {31'd0, clk_oe}, 32'd1);

    rst_n = 1'b1;
    ticks(4);
    chk("R1 release capture", {26'd0, modes()}, {26'd0, want(6'b101010)});
    chk("R10 ser_oe after reset", {31'd0, ser_oe}, 32'd1);
    chk("R5 thru raw rx", {24'd0, rx_sel}, {24'd0, rx_raw});
    chk("R5 thru raw tx", {24'd0, tx_sel}, {24'd0, tx_raw});

    // R4: edge inside lockout ignored, pins changed meanwhile
    pins = 6'b010101;
    frame_irq = 1'b0; ticks(3); frame_irq = 1'b1; ticks(6);
    chk("R4 modes kept in lockout", {26'd0, modes()}, {26'd0, want(6'b101010)});
    ticks(LOCK + 10);

    run_frame(6'b010100);   // hold set
    run_frame(6'b100011);   // through set
    chk("R5 thru raw rx", {24'd0, rx_sel}, {24'd0, rx_raw});

    // R3: pin change mid-frame without an edge
    pins = 6'b011111;
    ticks(10);
    chk("R3 modes unchanged", {26'd0, modes()}, {26'd0, want(6'b100011)});

    run_frame(6'b001000);   // normal processing
    chk("R5 proc rx", {24'd0, rx_sel}, {24'd0, rx_proc});
    chk("R5 proc tx", {24'd0, tx_sel}, {24'd0, tx_proc});

    // R11: power down and interrupt edge in the same cycle
    pins = 6'b110110;
    pwr_n = 1'b0; frame_irq = 1'b0;
    ticks(8);
    chk("R9 ser_oe in power down", {31'd0, ser_oe}, 32'd0);
    chk("R9 clk_oe in power down", {31'd0, clk_oe}, 32'd0);
    chk("R9 done held", {31'd0, frame_done}, 32'd1);
    chk("R11 modes kept", {26'd0, modes()}, {26'd0, want(6'b001000)});
    frame_irq = 1'b1; pwr_n = 1'b1;
    ticks(6);
    chk("R9 ser_oe restored", {31'd0, ser_oe}, 32'd1);
    chk("R11 no replay", {26'd0, modes()}, {26'd0, want(6'b001000)});

    run_frame(6'b000111);
    ticks(10);
    chk("R2 scoreboard drained", exp_q.size(), 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule